// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small processor core that carries out the steps of taking an interrupt and of leaving it. At an instruction boundary it chooses the most urgent pending source. A maskable hardware request only counts while the interrupt-enable bit is set. Non-maskable, trace, coprocessor-error and software requests are taken regardless of that bit. The block then saves the status word and the resume PC on a dedicated save stack and clears the enable bit. Next it reads the handler address from a vector table at `vt_base + vector * SCALE` and hands that address to the core on a one-cycle PC load.

A return strobe runs the inverse sequence. It pops the PC and then the status word, which brings back the earlier enable state, and reloads the PC. While a sequence runs, `busy` is high and the core must not issue instructions.

The stack port and the vector-table port are valid/ready channels. The block raises `valid` together with address, direction and write data, and keeps all of them stable until the cycle in which `ready` is also high. Read data is taken in that handshake cycle. A low `ready` simply stretches the sequence by one cycle and has no other effect.

Top module: `irq_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 0, `pc_load` is 1, `pc_val` equals RESET_PC (default 0x0010) and `sr_o` is 0. The save stack pointer returns to STK_TOP (default 0x0100). `pc_load` drops at the first clock edge after release.
- R2: A request is accepted only in a cycle where the block is idle and `insn_done` is 1. With `insn_done` low, nothing is taken and `busy` stays 0.
- R3: The maskable request (`hw_req`) counts only while the enable bit (status bit IE_BIT, default bit 0) is 1. When it wins, `hw_ack` is 1 in the acceptance cycle only, and `hw_vec` is captured in that cycle.
- R4: A software request (`swi_req`, vector `swi_vec`) is taken even when the enable bit is 0.
- R5: Entry performs two stack writes. The first writes the status word (zero-extended) at SP-1. The second writes the resume PC (`pc_i` captured at acceptance) at SP-2. SP ends two lower.
- R6: The enable bit is cleared after both saves. The pushed status word is the value before clearing. `sr_load` is ignored while `busy` is 1.
- R7: The table read address is `vt_base + vector*SCALE` (default SCALE 4). The word read there is driven on `pc_val` with `pc_load` high for one cycle.
- R8: When several requests are pending, the fixed priority from highest to lowest is software, trace (vector TRACE_VEC=1), non-maskable (NMI_VEC=2), coprocessor error (COP_VEC=5), maskable.
- R9: A non-maskable request (`nmi_req`) is taken while the enable bit is 0.
- R10: A return reads the PC at SP and then the status word at SP+1, leaving SP two higher. It restores the whole status word including the enable bit, and loads the popped PC through `pc_load`/`pc_val`.
- R11: `busy` is 1 from the cycle after acceptance until the cycle in which `pc_load` is 1, and is 0 in that cycle.
- R12: On both ports, a transfer happens only when valid and ready are both 1. While ready is low, valid, address, direction and write data hold, and the results are unchanged by stalls.
- R13: In the idle state `iret_req` is accepted without `insn_done`, and it wins over any interrupt request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Current instruction has completed |
| pc_i | input | AW | PC to resume at after the handler |
| hw_req | input | 1 | Maskable hardware request |
| hw_vec | input | VW | Vector number from the hardware source |
| hw_ack | output | 1 | Acknowledge of the maskable request |
| swi_req | input | 1 | Software interrupt strobe |
| swi_vec | input | VW | Software interrupt vector |
| trace_req | input | 1 | Single-step trace request |
| nmi_req | input | 1 | Non-maskable request |
| cop_err | input | 1 | Coprocessor error request |
| iret_req | input | 1 | Return-from-interrupt strobe |
| sr_load | input | 1 | Core write of the status word (idle only) |
| sr_load_data | input | SR_W | Status word value to write |
| sr_o | output | SR_W | Current status word |
| vt_base | input | AW | Vector table base register |
| vt_valid | output | 1 | Table read request valid |
| vt_ready | input | 1 | Table read ready |
| vt_addr | output | AW | Table read address |
| vt_rdata | input | DW | Table read data |
| stk_valid | output | 1 | Stack access valid |
| stk_ready | input | 1 | Stack access ready |
| stk_we | output | 1 | 1 = push write, 0 = pop read |
| stk_addr | output | AW | Stack address |
| stk_wdata | output | DW | Stack write data |
| stk_rdata | input | DW | Stack read data |
| pc_load | output | 1 | Load `pc_val` into the PC |
| pc_val | output | AW | New PC value |
| busy | output | 1 | Sequence in progress; core must not issue |

## Verification
The embedded properties assume several things about the surroundings. `vt_base` stays constant while a table read is outstanding. `iret_req` only arrives after a matching entry, so the save stack never underflows. A new request is not offered in the same cycle as `pc_load`. The bench holds the base at one value throughout and pairs every entry with a later return. It changes request inputs only on falling edges and issues the next request only after the pulse on `pc_load` has ended. Ready stalls are produced by a toggling pattern, so every hold interval is finite.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_FETCH,
    ST_POP_PC,
    ST_POP_SR
  } seq_state_t;

  // Source slots; a lower index means a higher priority.
  localparam int NUM_SRC   = 5;
  localparam int SRC_SWI   = 0;
  localparam int SRC_TRACE = 1;
  localparam int SRC_NMI   = 2;
  localparam int SRC_COP   = 3;
  localparam int SRC_HW    = 4;
endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic taken;

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign any = |req;

  // R8: never more than one winner
  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8: the top slot always wins when present
  assert_top_slot_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> grant[0]);
  // R8: a pending request always yields a grant
  assert_grant_when_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (grant != '0));
endmodule

// File: rtl/irq_seq_vaddr.sv
module irq_seq_vaddr #(
  parameter int AW    = 16,
  parameter int VW    = 5,
  parameter int SCALE = 4
) (
  input  logic [AW-1:0] base,
  input  logic [VW-1:0] vec,
  output logic [AW-1:0] addr
);
  localparam int SH = $clog2(SCALE);

  generate
    if (SH == 0) begin : g_unscaled
      assign addr = base + AW'(vec);
    end else begin : g_scaled
      assign addr = base + (AW'(vec) << SH);
    end
  endgenerate
endmodule

// File: rtl/irq_seq_stkptr.sv
module irq_seq_stkptr #(
  parameter int          AW      = 16,
  parameter logic [15:0] STK_TOP = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] push_addr,
  output logic [AW-1:0] pop_addr
);
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_q <= AW'(STK_TOP);
    else if (push) sp_q <= sp_q - AW'(1);
    else if (pop)  sp_q <= sp_q + AW'(1);
  end

  // pre-decrement on write, post-increment on read
  assign push_addr = sp_q - AW'(1);
  assign pop_addr  = sp_q;

  // R5 / R10: a stack step is either a push or a pop
  assert_push_pop_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          VW        = 5,
  parameter int          SR_W      = 8,
  parameter int          IE_BIT    = 0,
  parameter int          SCALE     = 4,
  parameter logic [15:0] RESET_PC  = 16'h0010,
  parameter logic [15:0] STK_TOP   = 16'h0100,
  parameter int          TRACE_VEC = 1,
  parameter int          NMI_VEC   = 2,
  parameter int          COP_VEC   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_done,
  input  logic [AW-1:0]   pc_i,
  input  logic            hw_req,
  input  logic [VW-1:0]   hw_vec,
  output logic            hw_ack,
  input  logic            swi_req,
  input  logic [VW-1:0]   swi_vec,
  input  logic            trace_req,
  input  logic            nmi_req,
  input  logic            cop_err,
  input  logic            iret_req,
  input  logic            sr_load,
  input  logic [SR_W-1:0] sr_load_data,
  output logic [SR_W-1:0] sr_o,
  input  logic [AW-1:0]   vt_base,
  output logic            vt_valid,
  input  logic            vt_ready,
  output logic [AW-1:0]   vt_addr,
  input  logic [DW-1:0]   vt_rdata,
  output logic            stk_valid,
  input  logic            stk_ready,
  output logic            stk_we,
  output logic [AW-1:0]   stk_addr,
  output logic [DW-1:0]   stk_wdata,
  input  logic [DW-1:0]   stk_rdata,
  output logic            pc_load,
  output logic [AW-1:0]   pc_val,
  output logic            busy
);
  seq_state_t          st_q, st_d;
  logic [SR_W-1:0]     sr_q;
  logic [VW-1:0]       vec_q;
  logic [AW-1:0]       pc_save_q;
  logic                pc_load_q;
  logic [AW-1:0]       pc_val_q;

  logic [NUM_SRC-1:0]  src_req, src_grant;
  logic                src_any;
  logic [VW-1:0]       src_vec [NUM_SRC];
  logic [VW-1:0]       sel_vec;
  logic                accept;
  logic                sp_push, sp_pop;
  logic [AW-1:0]       push_addr, pop_addr;

  // ---------------- request collection and arbitration ----------------
  assign src_req[SRC_SWI]   = swi_req;
  assign src_req[SRC_TRACE] = trace_req;
  assign src_req[SRC_NMI]   = nmi_req;
  assign src_req[SRC_COP]   = cop_err;
  assign src_req[SRC_HW]    = hw_req && sr_q[IE_BIT];

  assign src_vec[SRC_SWI]   = swi_vec;
  assign src_vec[SRC_TRACE] = VW'(TRACE_VEC);
  assign src_vec[SRC_NMI]   = VW'(NMI_VEC);
  assign src_vec[SRC_COP]   = VW'(COP_VEC);
  assign src_vec[SRC_HW]    = hw_vec;

  irq_seq_arb #(.N(NUM_SRC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (src_req),
    .grant (src_grant),
    .any   (src_any)
  );

  always_comb begin
    sel_vec = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_grant[i]) sel_vec = src_vec[i];
  end

  assign accept = (st_q == ST_IDLE) && !iret_req && insn_done && src_any;
  assign hw_ack = accept && src_grant[SRC_HW];

  // ---------------- save stack pointer and table address ----------------
  irq_seq_stkptr #(.AW(AW), .STK_TOP(STK_TOP)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (sp_push),
    .pop       (sp_pop),
    .push_addr (push_addr),
    .pop_addr  (pop_addr)
  );

  irq_seq_vaddr #(.AW(AW), .VW(VW), .SCALE(SCALE)) u_vaddr (
    .base (vt_base),
    .vec  (vec_q),
    .addr (vt_addr)
  );

  // ---------------- sequencer ----------------
  always_comb begin
    st_d      = st_q;
    stk_valid = 1'b0;
    stk_we    = 1'b0;
    stk_addr  = push_addr;
    stk_wdata = '0;
    vt_valid  = 1'b0;
    sp_push   = 1'b0;
    sp_pop    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (iret_req)    st_d = ST_POP_PC;
        else if (accept) st_d = ST_PUSH_SR;
      end
      ST_PUSH_SR: begin
        stk_valid = 1'b1;
        stk_we    = 1'b1;
        stk_wdata = DW'(sr_q);
        if (stk_ready) begin
          sp_push = 1'b1;
          st_d    = ST_PUSH_PC;
        end
      end
      ST_PUSH_PC: begin
        stk_valid = 1'b1;
        stk_we    = 1'b1;
        stk_wdata = DW'(pc_save_q);
        if (stk_ready) begin
          sp_push = 1'b1;
          st_d    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        vt_valid = 1'b1;
        if (vt_ready) st_d = ST_IDLE;
      end
      ST_POP_PC: begin
        stk_valid = 1'b1;
        stk_addr  = pop_addr;
        if (stk_ready) begin
          sp_pop = 1'b1;
          st_d   = ST_POP_SR;
        end
      end
      ST_POP_SR: begin
        stk_valid = 1'b1;
        stk_addr  = pop_addr;
        if (stk_ready) begin
          sp_pop = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sr_q      <= '0;
      vec_q     <= '0;
      pc_save_q <= '0;
      pc_load_q <= 1'b1;
      pc_val_q  <= AW'(RESET_PC);
    end else begin
      st_q      <= st_d;
      pc_load_q <= 1'b0;
      if (accept) begin
        vec_q     <= sel_vec;
        pc_save_q <= pc_i;
      end
      if (st_q == ST_IDLE && sr_load)
        sr_q <= sr_load_data;
      if (st_q == ST_PUSH_PC && stk_ready)
        sr_q[IE_BIT] <= 1'b0;
      if (st_q == ST_FETCH && vt_ready) begin
        pc_load_q <= 1'b1;
        pc_val_q  <= vt_rdata[AW-1:0];
      end
      if (st_q == ST_POP_PC && stk_ready)
        pc_save_q <= stk_rdata[AW-1:0];
      if (st_q == ST_POP_SR && stk_ready) begin
        sr_q      <= stk_rdata[SR_W-1:0];
        pc_load_q <= 1'b1;
        pc_val_q  <= pc_save_q;
      end
    end
  end

  assign sr_o    = sr_q;
  assign pc_load = pc_load_q;
  assign pc_val  = pc_val_q;
  assign busy    = (st_q != ST_IDLE);

  // ---------------- properties ----------------
  // R3: acknowledge implies interrupts enabled
  assert_ack_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |-> sr_q[IE_BIT]);
  // R2: acknowledge only from the idle state
  assert_ack_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |-> !busy);
  // R6: the enable bit is off by the time the table is read
  assert_enable_off_in_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH) |-> !sr_q[IE_BIT]);
  // R11: leaving busy coincides with a PC load
  assert_busy_ends_with_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pc_load);
  // R12: stack request held under back-pressure
  assert_stk_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) &&
                                   $stable(stk_we) && $stable(stk_wdata)));
  // R12: table request held under back-pressure
  assert_vt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (vt_valid && !vt_ready) |=> (vt_valid && $stable(vt_addr)));
endmodule

// File: tb/sim_irq_seq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_done = 1'b0;
  logic [15:0] pc_i = '0;
  logic        hw_req = 1'b0;
  logic [4:0]  hw_vec = '0;
  logic        hw_ack;
  logic        swi_req = 1'b0;
  logic [4:0]  swi_vec = '0;
  logic        trace_req = 1'b0, nmi_req = 1'b0, cop_err = 1'b0;
  logic        iret_req = 1'b0;
  logic        sr_load = 1'b0;
  logic [7:0]  sr_load_data = '0;
  logic [7:0]  sr_o;
  logic [15:0] vt_base = 16'h0400;
  logic        vt_valid, vt_ready;
  logic [15:0] vt_addr, vt_rdata;
  logic        stk_valid, stk_ready, stk_we;
  logic [15:0] stk_addr, stk_wdata, stk_rdata;
  logic        pc_load, busy;
  logic [15:0] pc_val;

  logic        stall_en = 1'b0;
  logic        tog = 1'b0;
  logic [15:0] mem [0:255];
  logic [15:0] wlog_a [0:15];
  logic [15:0] wlog_d [0:15];
  int          wn = 0;
  int          checks = 0, errors = 0;
  logic [15:0] sp_model = 16'h0100;

  always #10 clk = ~clk;

  irq_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .pc_i(pc_i),
    .hw_req(hw_req), .hw_vec(hw_vec), .hw_ack(hw_ack),
    .swi_req(swi_req), .swi_vec(swi_vec), .trace_req(trace_req),
    .nmi_req(nmi_req), .cop_err(cop_err), .iret_req(iret_req),
    .sr_load(sr_load), .sr_load_data(sr_load_data), .sr_o(sr_o),
    .vt_base(vt_base), .vt_valid(vt_valid), .vt_ready(vt_ready),
    .vt_addr(vt_addr), .vt_rdata(vt_rdata),
    .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_we(stk_we),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
    .pc_load(pc_load), .pc_val(pc_val), .busy(busy)
  );

  // memory models
  always @(negedge clk) tog <= ~tog;
  assign stk_ready = stall_en ? tog : 1'b1;
  assign vt_ready  = stall_en ? tog : 1'b1;
  assign vt_rdata  = vt_addr ^ 16'hA500;
  assign stk_rdata = mem[stk_addr[7:0]];

  always @(posedge clk) begin
    if (stk_valid && stk_ready && stk_we) begin
      mem[stk_addr[7:0]] <= stk_wdata;
      wlog_a[wn % 16]    <= stk_addr;
      wlog_d[wn % 16]    <= stk_wdata;
      wn                 <= wn + 1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wait_load(input string rq);
    int n = 0;
    while (pc_load !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk({rq, " pc_load seen"}, {31'd0, pc_load}, 32'd1);
  endtask

  task automatic set_sr(input logic [7:0] v);
    @(negedge clk);
    sr_load = 1'b1; sr_load_data = v;
    @(negedge clk);
    sr_load = 1'b0;
    chk("R6 status write in idle", {24'd0, sr_o}, {24'd0, v});
  endtask

  // reqs bits: 0 software, 1 trace, 2 nmi, 3 coprocessor, 4 maskable
  task automatic enter(input logic [4:0] reqs, input logic [4:0] swv, input logic [4:0] hwv,
                       input logic [15:0] pc, input logic [4:0] ev, input logic eack,
                       input string rq);
    logic [7:0]  sr_before;
    logic [15:0] exp_pc;
    int          wb;
    @(negedge clk);
    sr_before = sr_o;
    wb = wn;
    swi_req = reqs[0]; trace_req = reqs[1]; nmi_req = reqs[2];
    cop_err = reqs[3]; hw_req = reqs[4];
    swi_vec = swv; hw_vec = hwv; pc_i = pc; insn_done = 1'b1;
    #1 chk({rq, " R3 ack in accept cycle"}, {31'd0, hw_ack}, {31'd0, eack});
    @(negedge clk);
    swi_req = 0; trace_req = 0; nmi_req = 0; cop_err = 0; hw_req = 0; insn_done = 0;
    chk({rq, " R11 busy after accept"}, {31'd0, busy}, 32'd1);
    sr_load = 1'b1; sr_load_data = 8'hFF;   // must be ignored (R6)
    @(negedge clk);
    sr_load = 1'b0;
    wait_load(rq);
    exp_pc = (16'h0400 + {9'd0, ev, 2'b00}) ^ 16'hA500;
    chk({rq, " R7 table word to pc"}, {16'd0, pc_val}, {16'd0, exp_pc});
    chk({rq, " R11 busy low at load"}, {31'd0, busy}, 32'd0);
    chk({rq, " R5 two writes"}, wn - wb, 2);
    chk({rq, " R5 status addr"}, {16'd0, wlog_a[wb % 16]}, {16'd0, sp_model - 16'd1});
    chk({rq, " R5 status data"}, {16'd0, wlog_d[wb % 16]}, {24'd0, sr_before});
    chk({rq, " R5 pc addr"}, {16'd0, wlog_a[(wb + 1) % 16]}, {16'd0, sp_model - 16'd2});
    chk({rq, " R5 pc data"}, {16'd0, wlog_d[(wb + 1) % 16]}, {16'd0, pc});
    chk({rq, " R6 enable cleared, rest kept"}, {24'd0, sr_o}, {24'd0, sr_before & 8'hFE});
    sp_model = sp_model - 16'd2;
    @(negedge clk);
    chk({rq, " R7 load is one cycle"}, {31'd0, pc_load}, 32'd0);
  endtask

  task automatic leave(input logic [15:0] epc, input logic [7:0] esr, input logic contend,
                       input string rq);
    int wb;
    @(negedge clk);
    wb = wn;
    iret_req = 1'b1;
    if (contend) begin
      insn_done = 1'b1; swi_req = 1'b1; swi_vec = 5'd11;
    end
    @(negedge clk);
    iret_req = 0; insn_done = 0; swi_req = 0;
    chk({rq, " R11 busy during return"}, {31'd0, busy}, 32'd1);
    wait_load(rq);
    chk({rq, " R10 popped pc"}, {16'd0, pc_val}, {16'd0, epc});
    chk({rq, " R10 status restored"}, {24'd0, sr_o}, {24'd0, esr});
    chk({rq, " R10 no writes on return"}, wn - wb, 0);
    sp_model = sp_model + 16'd2;
    @(negedge clk);
  endtask

  task automatic t_reset();
    #35;
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 pc_load in reset", {31'd0, pc_load}, 32'd1);
    chk("R1 reset pc", {16'd0, pc_val}, 32'h0010);
    chk("R1 status cleared", {24'd0, sr_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc_load drops", {31'd0, pc_load}, 32'd0);
  endtask

  task automatic t_no_boundary();
    set_sr(8'h01);
    @(negedge clk);
    hw_req = 1'b1; hw_vec = 5'd3; insn_done = 1'b0;
    #1 chk("R2 no ack without boundary", {31'd0, hw_ack}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 not taken without boundary", {31'd0, busy}, 32'd0);
    hw_req = 1'b0;
  endtask

  task automatic t_masked();
    set_sr(8'h00);
    @(negedge clk);
    hw_req = 1'b1; insn_done = 1'b1;
    #1 chk("R3 masked no ack", {31'd0, hw_ack}, 32'd0);
    @(negedge clk);
    chk("R3 masked not taken", {31'd0, busy}, 32'd0);
    hw_req = 1'b0; insn_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_no_boundary();
    t_masked();
    // R3 maskable entry and R10 return
    set_sr(8'h5B);
    enter(5'b10000, 5'd0, 5'd3, 16'h1234, 5'd3, 1'b1, "R3 maskable");
    leave(16'h1234, 8'h5B, 1'b0, "R10 return");
    // R4 software with enable off
    set_sr(8'h00);
    enter(5'b00001, 5'd9, 5'd0, 16'h2000, 5'd9, 1'b0, "R4 software");
    leave(16'h2000, 8'h00, 1'b0, "R4 return");
    // R9 non-maskable with enable off
    enter(5'b10100, 5'd0, 5'd8, 16'h2100, 5'd2, 1'b0, "R9 nmi");
    leave(16'h2100, 8'h00, 1'b0, "R9 return");
    // R8 priority ladder with enable on
    set_sr(8'h01);
    enter(5'b11110, 5'd0, 5'd8, 16'h2200, 5'd1, 1'b0, "R8 trace wins");
    leave(16'h2200, 8'h01, 1'b0, "R8 return a");
    enter(5'b11100, 5'd0, 5'd8, 16'h2300, 5'd2, 1'b0, "R8 nmi wins");
    leave(16'h2300, 8'h01, 1'b0, "R8 return b");
    enter(5'b11000, 5'd0, 5'd8, 16'h2400, 5'd5, 1'b0, "R8 cop wins");
    leave(16'h2400, 8'h01, 1'b0, "R8 return c");
    enter(5'b11111, 5'd7, 5'd8, 16'h2500, 5'd7, 1'b0, "R8 software wins");
    leave(16'h2500, 8'h01, 1'b0, "R8 return d");
    // R12 back-pressure on both ports
    set_sr(8'h33);
    stall_en = 1'b1;
    enter(5'b10000, 5'd0, 5'd17, 16'h2600, 5'd17, 1'b1, "R12 stalled entry");
    leave(16'h2600, 8'h33, 1'b0, "R12 stalled return");
    stall_en = 1'b0;
    // R10 nested entries and returns
    set_sr(8'h01);
    enter(5'b00001, 5'd4, 5'd0, 16'h3000, 5'd4, 1'b0, "R10 outer");
    enter(5'b00001, 5'd6, 5'd0, 16'h3100, 5'd6, 1'b0, "R10 inner");
    leave(16'h3100, 8'h00, 1'b0, "R10 inner return");
    leave(16'h3000, 8'h01, 1'b0, "R10 outer return");
    // R13 return beats a same-cycle request
    enter(5'b00001, 5'd4, 5'd0, 16'h4000, 5'd4, 1'b0, "R13 setup");
    leave(16'h4000, 8'h01, 1'b1, "R13 return wins");
    chk("R13 back to idle", {31'd0, busy}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule